// File: doc/BRIEF.md
# Deferred Host Write Port for Shared Video Memory

A slow host processor writes command bytes into a video memory that a display scanout engine reads almost all of the time. This block watches host write cycles. When one targets the command window at the top of the 64K address space, it captures the address and the data byte. Those captured values are what the video memory sees for the write. An address in the window maps to the same video memory address, so the captured address is passed through unchanged.

The block never takes the memory away from scanout while visible pixels or sync are being produced. A write that arrives in such a period stays pending, and the host ready line goes low so the host can wait. As soon as scanout reports an idle window, the block runs a fixed handover. It first closes the memory read path, then opens the host bus buffers, then pulses the write strobe, and then returns the bus to scanout. The block clock runs at twenty times the host clock, so a write that is not deferred finishes well inside one host cycle.

Only one write can be held at a time. A further window access while one is held is not captured. It keeps ready low until the held write is done.

Top module: `vram_host_arbiter`

## Requirements
- R1: A `host_sel` pulse whose address is in 0xF400..0xFFFF starts a write. An address below 0xF400 (for example 0x0000, 0xEFFF, 0xF3FF) is ignored: the controls stay at their idle levels (`buf_oe_n`=1, `vram_oe_n`=0, `vram_we_n`=1) and `host_ready` stays 1.
- R2: On a captured write, `wr_addr` equals the host address and `wr_data` equals the host data from the clock after capture until the next capture.
- R3: While `scan_busy` is 1, a held write does not start. The handover begins on the first clock edge at which `scan_busy` is sampled 0.
- R4: The handover runs in this order, one clock per step, counted from the edge that starts it. Step 1: `vram_oe_n` goes to 1. Step 2: `buf_oe_n` goes to 0. Steps 3 to 2+STROBE_CYC: `vram_we_n` is 0 with `buf_oe_n` still 0. Next step: `buf_oe_n` and `vram_we_n` return to 1. The step after that: `vram_oe_n` returns to 0.
- R5: `vram_we_n` and `vram_oe_n` are never 0 in the same cycle.
- R6: `buf_oe_n` and `vram_oe_n` are never 0 in the same cycle.
- R7: The write strobe is low for STROBE_CYC cycles, which is at least 2. The whole handover fits in CLK_RATIO block clocks.
- R8: `host_ready` stays 1 for a write that starts at once. For a write captured while `scan_busy` is 1, `host_ready` is 0 from the clock after capture until the cycle in which `vram_oe_n` returns to 0.
- R9: An in-window `host_sel` while a write is held or in progress is not captured (`wr_addr` and `wr_data` keep the first values, and no second handover follows). It drives `host_ready` to 0 from the next clock until the first write completes.
- R10: After reset, `buf_oe_n`=1, `vram_we_n`=1, `vram_oe_n`=0 and `host_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twenty times the host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | One-clock pulse marking a host write cycle |
| host_addr | input | 16 | Host address for the write |
| host_data | input | 8 | Host data byte for the write |
| scan_busy | input | 1 | High while scanout produces pixels or sync |
| host_ready | output | 1 | Low while the host must stall |
| wr_addr | output | 16 | Captured video memory write address |
| wr_data | output | 8 | Captured write data |
| buf_oe_n | output | 1 | Host bus buffer enable, active low |
| vram_oe_n | output | 1 | Video memory output enable, active low |
| vram_we_n | output | 1 | Video memory write strobe, active low |

## Verification
A handover state left wrong shows up at the three control pins within a clock. Either two of them overlap low, or the strobe runs too short, or `vram_oe_n` never returns low, and the ordering properties catch each case on the next edge. A stall flag that is set or cleared wrongly shows on `host_ready` in the clock after the capture or the collision. A decode error appears at once as a missing or spurious handover on a pulse at one of the window boundaries. A capture register loaded at the wrong time shows as a changed `wr_addr` after a colliding access.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PEND,
      ST_OEOFF,
      ST_BUF,
      ST_STROBE,
      ST_RELEASE
   } hand_state_t;

   typedef struct packed {
      logic buf_n;
      logic oe_n;
      logic we_n;
   } ctrl_t;

   localparam ctrl_t CTRL_SCAN = '{buf_n: 1'b1, oe_n: 1'b0, we_n: 1'b1};
   localparam ctrl_t CTRL_QUIET = '{buf_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};
   localparam ctrl_t CTRL_OPEN = '{buf_n: 1'b0, oe_n: 1'b1, we_n: 1'b1};
   localparam ctrl_t CTRL_WRITE = '{buf_n: 1'b0, oe_n: 1'b1, we_n: 1'b0};

   function automatic ctrl_t ctrl_of(hand_state_t s);
      case (s)
         ST_OEOFF:   return CTRL_QUIET;
         ST_BUF:     return CTRL_OPEN;
         ST_STROBE:  return CTRL_WRITE;
         ST_RELEASE: return CTRL_QUIET;
         default:    return CTRL_SCAN;
      endcase
   endfunction

endpackage

// File: rtl/vram_win_decode.sv
module vram_win_decode #(
   parameter int ADDR_W   = 16,
   parameter int WIN_BASE = 'hF400,
   parameter int WIN_LAST = 'hFFFF
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WIN_BASE);
   localparam logic [ADDR_W-1:0] LAST_V = ADDR_W'(WIN_LAST);
   localparam bit AT_TOP = (WIN_LAST == (2 ** ADDR_W) - 1);

   if (WIN_BASE > WIN_LAST) begin : g_bad_window
      $error("window base above window end");
   end

   if (AT_TOP) begin : g_top_window
      // Window reaches the top of the space: one comparator suffices.
      assign hit = (addr >= BASE_V);
   end else begin : g_mid_window
      assign hit = (addr >= BASE_V) && (addr <= LAST_V);
   end
endmodule

// File: rtl/vram_req_latch.sv
module vram_req_latch #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (load) begin
         addr_q <= addr_in;
         data_q <= data_in;
      end
   end
endmodule

// File: rtl/vram_handover_fsm.sv
module vram_handover_fsm
   import vram_arb_pkg::*;
#(
   parameter int STROBE_CYC = 2,
   parameter int CLK_RATIO  = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_hit,
   input  logic scan_busy,
   output logic accept,
   output logic host_ready,
   output ctrl_t ctrl
);
   localparam int CNT_W = (STROBE_CYC < 2) ? 1 : $clog2(STROBE_CYC);
   localparam int SEQ_LEN = STROBE_CYC + 4;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CYC - 1);

   if (STROBE_CYC < 2) begin : g_bad_strobe
      $error("write strobe must last at least two clocks");
   end
   if (SEQ_LEN > CLK_RATIO) begin : g_bad_ratio
      $error("handover does not fit in one host clock");
   end

   hand_state_t state, nxt;
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic stall, stall_nxt, collide;

   assign accept  = sel_hit && (state == ST_IDLE);
   assign collide = sel_hit && (state != ST_IDLE);

   always_comb begin
      nxt     = state;
      cnt_nxt = cnt;
      case (state)
         ST_IDLE:    if (accept) nxt = scan_busy ? ST_PEND : ST_OEOFF;
         ST_PEND:    if (!scan_busy) nxt = ST_OEOFF;
         ST_OEOFF:   nxt = ST_BUF;
         ST_BUF: begin
            nxt     = ST_STROBE;
            cnt_nxt = CNT_LOAD;
         end
         ST_STROBE: begin
            if (cnt == '0) nxt = ST_RELEASE;
            else cnt_nxt = cnt - 1'b1;
         end
         ST_RELEASE: nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
   end

   always_comb begin
      if (state == ST_RELEASE) stall_nxt = 1'b0;
      else stall_nxt = stall || (accept && scan_busy) || collide;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         stall <= 1'b0;
      end else begin
         state <= nxt;
         cnt   <= cnt_nxt;
         stall <= stall_nxt;
      end
   end

   assign ctrl       = ctrl_of(state);
   assign host_ready = !stall;
endmodule

// File: rtl/vram_host_arbiter.sv
module vram_host_arbiter
   import vram_arb_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int WIN_BASE   = 'hF400,
   parameter int WIN_LAST   = 'hFFFF,
   parameter int STROBE_CYC = 2,
   parameter int CLK_RATIO  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_data,
   input  logic              scan_busy,
   output logic              host_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              buf_oe_n,
   output logic              vram_oe_n,
   output logic              vram_we_n
);
   logic  hit, accept;
   ctrl_t ctrl;

   vram_win_decode #(
      .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)
   ) u_dec (
      .addr(host_addr), .hit(hit)
   );

   vram_handover_fsm #(
      .STROBE_CYC(STROBE_CYC), .CLK_RATIO(CLK_RATIO)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .sel_hit(host_sel && hit),
      .scan_busy(scan_busy), .accept(accept),
      .host_ready(host_ready), .ctrl(ctrl)
   );

   vram_req_latch #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_lat (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .addr_in(host_addr), .data_in(host_data),
      .addr_q(wr_addr), .data_q(wr_data)
   );

   assign buf_oe_n  = ctrl.buf_n;
   assign vram_oe_n = ctrl.oe_n;
   assign vram_we_n = ctrl.we_n;
endmodule

// File: rtl/vram_host_arbiter_chk.sv
module vram_host_arbiter_chk (
   input logic clk,
   input logic rst_n,
   input logic scan_busy,
   input logic host_ready,
   input logic buf_oe_n,
   input logic vram_oe_n,
   input logic vram_we_n
);
   a_r5_we_oe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!vram_we_n && !vram_oe_n));

   a_r6_buf_oe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!buf_oe_n && !vram_oe_n));

   a_r4_strobe_in_buf: assert property (@(posedge clk) disable iff (!rst_n)
      !vram_we_n |-> !buf_oe_n);

   a_r4_open_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(buf_oe_n) |-> ($past(vram_oe_n) && vram_oe_n));

   a_r4_restore_after_close: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vram_oe_n) |-> $past(buf_oe_n));

   a_r3_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vram_oe_n) |-> !$past(scan_busy));

   a_r7_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vram_we_n) |-> !$past(vram_we_n, 2));

   a_r8_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_ready) |-> $fell(vram_oe_n));
endmodule

bind vram_host_arbiter vram_host_arbiter_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scan_busy(scan_busy), .host_ready(host_ready),
   .buf_oe_n(buf_oe_n), .vram_oe_n(vram_oe_n), .vram_we_n(vram_we_n)
);

// File: tb/vram_host_arbiter_test.sv
module vram_host_arbiter_test;
   localparam int STRB = 2;
   localparam int LAST_K = STRB + 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_sel = 1'b0, scan_busy = 1'b0;
   logic [15:0] host_addr = '0;
   logic [7:0]  host_data = '0;
   logic host_ready, buf_oe_n, vram_oe_n, vram_we_n;
   logic [15:0] wr_addr;
   logic [7:0]  wr_data;
   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   vram_host_arbiter uut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_addr(host_addr),
      .host_data(host_data), .scan_busy(scan_busy), .host_ready(host_ready),
      .wr_addr(wr_addr), .wr_data(wr_data), .buf_oe_n(buf_oe_n),
      .vram_oe_n(vram_oe_n), .vram_we_n(vram_we_n)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
      end
   endtask

   // controls as {buf_oe_n, vram_oe_n, vram_we_n}
   function automatic logic [2:0] ctrl_at(int k);
      if (k == 1) return 3'b111;
      if (k == 2) return 3'b011;
      if (k <= 2 + STRB) return 3'b010;
      if (k == 3 + STRB) return 3'b111;
      return 3'b101;
   endfunction

   // Present a pulse; returns at the sample point after the capture edge.
   task automatic pulse(logic [15:0] a, logic [7:0] d, logic busy);
      host_sel = 1'b1; host_addr = a; host_data = d; scan_busy = busy;
      step();
      host_sel = 1'b0;
   endtask

   // Check the handover from step 1 (current sample) to LAST_K.
   task automatic expect_seq(string rq, logic [15:0] a, logic [7:0] d,
                             int stall_from, int collide_at);
      for (int k = 1; k <= LAST_K; k++) begin
         check(rq, {buf_oe_n, vram_oe_n, vram_we_n}, ctrl_at(k));
         check("R8", host_ready, (k >= stall_from && k < LAST_K) ? 1'b0 : 1'b1);
         check("R2", {wr_addr, wr_data}, {a, d});
         if (k == collide_at) begin
            host_sel = 1'b1; host_addr = ~a | 16'hF400; host_data = ~d;
         end
         if (k < LAST_K) step();
         host_sel = 1'b0;
      end
   endtask

   task automatic expect_quiet(string rq, int n);
      for (int k = 0; k < n; k++) begin
         check(rq, {buf_oe_n, vram_oe_n, vram_we_n, host_ready}, 4'b1011);
         step();
      end
   endtask

   task automatic run_one(logic [15:0] a, logic [7:0] d);
      pulse(a, d, 1'b0);
      if (a >= 16'hF400) begin
         expect_seq("R1", a, d, 99, 0);
         step();
      end else begin
         expect_quiet("R1", LAST_K);
      end
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      // R10 reset state
      check("R10", {buf_oe_n, vram_oe_n, vram_we_n, host_ready}, 4'b1011);
      rst_n = 1'b1;
      step();
      check("R10", {buf_oe_n, vram_oe_n, vram_we_n, host_ready}, 4'b1011);

      // R1 window boundaries
      run_one(16'h0000, 8'h11);
      run_one(16'hEFFF, 8'h22);
      run_one(16'hF3FF, 8'h33);
      run_one(16'hF400, 8'h44);
      run_one(16'hFFFF, 8'h55);

      // R1 R2 R4 sweep across the space
      for (int i = 0; i < 256; i++) begin
         logic [7:0] b = i[7:0];
         run_one({b, ~b}, b ^ 8'h5A);
      end

      // R3 R8 deferral with several busy lengths
      for (int dly = 1; dly <= 5; dly++) begin
         logic [15:0] a = 16'hF500 + 16'(dly);
         pulse(a, 8'(dly), 1'b1);
         for (int j = 0; j < dly; j++) begin
            check("R3", {buf_oe_n, vram_oe_n, vram_we_n, host_ready}, 4'b1010);
            check("R2", {wr_addr, wr_data}, {a, 8'(dly)});
            step();
         end
         scan_busy = 1'b0;
         step();
         expect_seq("R3", a, 8'(dly), 1, 0);
         step();
         expect_quiet("R4", 2);
      end

      // R9 collision while held: not captured, single handover
      pulse(16'hF800, 8'hA5, 1'b1);
      host_sel = 1'b1; host_addr = 16'hFC00; host_data = 8'h3C;
      step();
      host_sel = 1'b0;
      check("R9", {wr_addr, wr_data}, {16'hF800, 8'hA5});
      check("R9", host_ready, 1'b0);
      step();
      scan_busy = 1'b0;
      step();
      expect_seq("R9", 16'hF800, 8'hA5, 1, 0);
      step();
      expect_quiet("R9", 4);

      // R9 collision during a handover that started at once
      for (int c = 1; c <= 3; c++) begin
         pulse(16'hF900 + 16'(c), 8'hC0, 1'b0);
         expect_seq("R9", 16'hF900 + 16'(c), 8'hC0, c + 1, c);
         step();
         expect_quiet("R9", 3);
      end

      // R7 strobe length and total handover inside CLK_RATIO
      pulse(16'hFA00, 8'h77, 1'b0);
      begin
         int low = 0, total = 0;
         for (int k = 0; k < 20; k++) begin
            if (!vram_we_n) low++;
            if (vram_oe_n) total++;
            step();
         end
         check("R7", 32'(low), 32'(STRB));
         check("R7", 32'(total <= 20), 32'd1);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule